// File: doc/BRIEF.md
# Fair Masked Interrupt Selector

This block gathers level interrupt requests from up to `NUM_SRC` on-chip peripherals and qualifies them with an enable mask that software owns. A source counts as pending only while its request line and its enable bit are both high. Whenever any source is pending, a single registered request line toward the processor is raised.

When the processor pulses `next_req`, the block picks one pending source and reports it one cycle later. No source has priority over another. The search begins at a stored pointer and walks upward, wrapping past the top index. After each pick, the pointer moves to one past the source just served, so every pending source is reached in turn.

The mask can be loaded whole, or a single bit can be set or cleared without touching the others. A contiguous window of source indices can be declared as cascaded external lines. A pick inside that window is also reported as a local line number.

Top module: `fair_irq_selector`

## Requirements
- R1: A source is pending only when `src_status[i]` and mask bit i are both 1; a reported `sel_index` always names a source that was pending in the cycle of the request.
- R2: A `next_req` while nothing is pending gives `sel_valid` = 0 and leaves the search pointer unchanged, so the next successful search starts where it would have started anyway.
- R3: The search takes the first pending index at or above the pointer. If there is none, it wraps and takes the first pending index from 0 upward.
- R4: After a pick of index k, the pointer becomes (k+1) mod `NUM_SRC`.
- R5: Mask writes with `mask_wr` = 1 use `mask_op` as follows: 2'b00 loads `mask_wdata` whole, 2'b01 sets bit `mask_bit`, 2'b10 clears bit `mask_bit`, and 2'b11 changes nothing. A set or clear alters no other mask bit. `mask_out` shows the mask register.
- R6: When `EXT_EN` = 1 and the picked index k lies in [`EXT_LO`, `EXT_HI`], `sel_is_external` = 1 and `sel_ext_line` = k − `EXT_LO`. Otherwise both are 0.
- R7: `sel_valid`, `sel_index`, `sel_is_external` and `sel_ext_line` are registered. They appear one cycle after the `next_req` cycle. In any cycle without a pick, all four are 0.
- R8: `irq_out` is a registered OR of all pending bits, one cycle behind the status and mask.
- R9: After reset the mask is all zeros, the pointer is 0, and `irq_out` and all selection outputs are 0.
- R10: When a mask write and `next_req` fall in the same cycle, the pick uses the mask as it stood before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_status | input | NUM_SRC | Level request from each peripheral |
| mask_wr | input | 1 | Mask update strobe |
| mask_op | input | 2 | Mask operation: load, set bit, clear bit, none |
| mask_wdata | input | NUM_SRC | Whole-mask value for the load operation |
| mask_bit | input | IDXW | Bit index for set and clear |
| mask_out | output | NUM_SRC | Current mask register |
| next_req | input | 1 | Processor asks for the next source |
| irq_out | output | 1 | Any enabled source pending (registered) |
| sel_valid | output | 1 | A source was picked for the last request |
| sel_index | output | IDXW | Picked source index |
| sel_is_external | output | 1 | Picked index is in the external window |
| sel_ext_line | output | IDXW | Line number within the external window |

## Verification
A mask update and a selection can fall in the same cycle. The bench provokes this in a directed case, where the only pending source is cleared in the very cycle it is requested, and again many times in the random phase, where `mask_wr` and `next_req` are drawn independently. In each such cycle, the pick is judged against a model that uses the mask from before the write. The mask is then checked after the write, and the following request is checked to see that the cleared source is no longer picked.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
    typedef enum logic [1:0] {
        MASK_LOAD = 2'b00,
        MASK_SET  = 2'b01,
        MASK_CLR  = 2'b10,
        MASK_HOLD = 2'b11
    } mask_op_e;
endpackage

// File: rtl/fsel_mask_next.sv
module fsel_mask_next #(
    parameter int NUM_SRC = 32,
    localparam int IDXW = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] mask_q,
    input  logic               wr,
    input  logic [1:0]         op,
    input  logic [NUM_SRC-1:0] wdata,
    input  logic [IDXW-1:0]    bit_idx,
    output logic [NUM_SRC-1:0] mask_d
);
    import fsel_pkg::*;

    logic [NUM_SRC-1:0] one_hot;

    always_comb begin
        one_hot = '0;
        one_hot[bit_idx] = 1'b1;
        mask_d = mask_q;
        if (wr) begin
            unique case (mask_op_e'(op))
                MASK_LOAD: mask_d = wdata;
                MASK_SET:  mask_d = mask_q | one_hot;
                MASK_CLR:  mask_d = mask_q & ~one_hot;
                default:   mask_d = mask_q;
            endcase
        end
    end
endmodule

// File: rtl/fsel_rr_pick.sv
module fsel_rr_pick #(
    parameter int NUM_SRC = 32,
    localparam int IDXW = $clog2(NUM_SRC),
    localparam int DBL  = 2 * NUM_SRC
) (
    input  logic [NUM_SRC-1:0] pend,
    input  logic [IDXW-1:0]    ptr,
    output logic               hit,
    output logic [IDXW-1:0]    idx
);
    logic [DBL-1:0] dbl_vec;
    logic [DBL-1:0] window;
    logic [IDXW:0]  pos;

    assign dbl_vec = {pend, pend};

    for (genvar g = 0; g < DBL; g++) begin : g_win
        assign window[g] = dbl_vec[g] && (g >= int'(ptr));
    end

    always_comb begin
        hit = 1'b0;
        pos = '0;
        for (int i = DBL - 1; i >= 0; i--) begin
            if (window[i]) begin
                hit = 1'b1;
                pos = (IDXW + 1)'(i);
            end
        end
        if (int'(pos) >= NUM_SRC) idx = IDXW'(int'(pos) - NUM_SRC);
        else                      idx = IDXW'(pos);
    end
endmodule

// File: rtl/fsel_ext_map.sv
module fsel_ext_map #(
    parameter int NUM_SRC = 32,
    parameter bit EXT_EN  = 1'b1,
    parameter int EXT_LO  = 28,
    parameter int EXT_HI  = 31,
    localparam int IDXW = $clog2(NUM_SRC)
) (
    input  logic [IDXW-1:0] idx,
    output logic            is_ext,
    output logic [IDXW-1:0] line
);
    if (EXT_EN) begin : g_ext
        always_comb begin
            is_ext = (int'(idx) >= EXT_LO) && (int'(idx) <= EXT_HI);
            line   = is_ext ? IDXW'(int'(idx) - EXT_LO) : '0;
        end
    end else begin : g_noext
        assign is_ext = 1'b0;
        assign line   = '0;
    end
endmodule

// File: rtl/fair_irq_selector.sv
module fair_irq_selector #(
    parameter int NUM_SRC = 32,
    parameter bit EXT_EN  = 1'b1,
    parameter int EXT_LO  = 28,
    parameter int EXT_HI  = 31,
    localparam int IDXW = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_status,
    input  logic               mask_wr,
    input  logic [1:0]         mask_op,
    input  logic [NUM_SRC-1:0] mask_wdata,
    input  logic [IDXW-1:0]    mask_bit,
    output logic [NUM_SRC-1:0] mask_out,
    input  logic               next_req,
    output logic               irq_out,
    output logic               sel_valid,
    output logic [IDXW-1:0]    sel_index,
    output logic               sel_is_external,
    output logic [IDXW-1:0]    sel_ext_line
);
    import fsel_pkg::*;

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic [IDXW-1:0]    ptr;
        logic               irq;
        logic               valid;
        logic [IDXW-1:0]    idx;
        logic               ext;
        logic [IDXW-1:0]    line;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SRC-1:0] pend_w;
    logic [NUM_SRC-1:0] mask_nx;
    logic               pick_hit;
    logic [IDXW-1:0]    pick_idx;
    logic               pick_ext;
    logic [IDXW-1:0]    pick_line;

    assign pend_w = src_status & st_q.mask;

    fsel_mask_next #(.NUM_SRC(NUM_SRC)) u_mask (
        .mask_q (st_q.mask),
        .wr     (mask_wr),
        .op     (mask_op),
        .wdata  (mask_wdata),
        .bit_idx(mask_bit),
        .mask_d (mask_nx)
    );

    fsel_rr_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .pend(pend_w),
        .ptr (st_q.ptr),
        .hit (pick_hit),
        .idx (pick_idx)
    );

    fsel_ext_map #(
        .NUM_SRC(NUM_SRC), .EXT_EN(EXT_EN), .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)
    ) u_ext (
        .idx   (pick_idx),
        .is_ext(pick_ext),
        .line  (pick_line)
    );

    always_comb begin
        st_d       = st_q;
        st_d.mask  = mask_nx;
        st_d.irq   = |pend_w;
        st_d.valid = 1'b0;
        st_d.idx   = '0;
        st_d.ext   = 1'b0;
        st_d.line  = '0;
        if (next_req && pick_hit) begin
            st_d.valid = 1'b1;
            st_d.idx   = pick_idx;
            st_d.ext   = pick_ext;
            st_d.line  = pick_line;
            st_d.ptr   = (int'(pick_idx) == NUM_SRC - 1) ? '0 : pick_idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_out        = st_q.mask;
    assign irq_out         = st_q.irq;
    assign sel_valid       = st_q.valid;
    assign sel_index       = st_q.idx;
    assign sel_is_external = st_q.ext;
    assign sel_ext_line    = st_q.line;

    // R1
    pick_was_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> ((($past(pend_w) >> sel_index) & NUM_SRC'(1)) != '0));

    // R2
    idle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (next_req && pend_w == '0) |=> (!sel_valid && $stable(st_q.ptr)));

    // R4
    ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (int'(st_q.ptr) == (int'(sel_index) + 1) % NUM_SRC));

    // R5
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && mask_op == 2'b10) |=>
        (mask_out == ($past(mask_out) & ~(NUM_SRC'(1) << $past(mask_bit)))));

    // R6
    ext_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_is_external |-> (sel_valid && int'(sel_index) >= EXT_LO && int'(sel_index) <= EXT_HI));

    // R7
    valid_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> $past(next_req));

    // R8
    irq_follows_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(pend_w != '0));
endmodule

// File: tb/tb_fair_irq_selector.sv
module tb_fair_irq_selector;
    localparam int N      = 32;
    localparam int EXT_LO = 28;
    localparam int EXT_HI = 31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_status = '0;
    logic        mask_wr = 1'b0;
    logic [1:0]  mask_op = 2'b11;
    logic [31:0] mask_wdata = '0;
    logic [4:0]  mask_bit = '0;
    logic [31:0] mask_out;
    logic        next_req = 1'b0;
    logic        irq_out, sel_valid, sel_is_external;
    logic [4:0]  sel_index, sel_ext_line;

    int checks = 0;
    int fails = 0;
    logic [31:0] m_mask = '0;
    int          m_ptr = 0;

    always #4 clk = ~clk;

    fair_irq_selector dut (
        .clk(clk), .rst_n(rst_n), .src_status(src_status),
        .mask_wr(mask_wr), .mask_op(mask_op), .mask_wdata(mask_wdata),
        .mask_bit(mask_bit), .mask_out(mask_out), .next_req(next_req),
        .irq_out(irq_out), .sel_valid(sel_valid), .sel_index(sel_index),
        .sel_is_external(sel_is_external), .sel_ext_line(sel_ext_line)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int model_pick(logic [31:0] pend, int ptr);
        for (int k = 0; k < N; k++) begin
            int j = (ptr + k) % N;
            if (pend[j]) return j;
        end
        return -1;
    endfunction

    task automatic step(string tag, logic [31:0] stat, logic wr, logic [1:0] op,
                        logic [31:0] wd, logic [4:0] bt, logic req);
        logic [31:0] pend;
        int          pk;
        logic        e_valid, e_ext;
        logic [4:0]  e_idx, e_line;
        src_status = stat; mask_wr = wr; mask_op = op;
        mask_wdata = wd; mask_bit = bt; next_req = req;
        pend = stat & m_mask;
        pk = req ? model_pick(pend, m_ptr) : -1;
        e_valid = (pk >= 0);
        e_idx   = e_valid ? 5'(pk) : 5'd0;
        e_ext   = e_valid && pk >= EXT_LO && pk <= EXT_HI;
        e_line  = e_ext ? 5'(pk - EXT_LO) : 5'd0;
        if (e_valid) m_ptr = (pk + 1) % N;
        if (wr) begin
            case (op)
                2'b00: m_mask = wd;
                2'b01: m_mask[bt] = 1'b1;
                2'b10: m_mask[bt] = 1'b0;
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        check({tag, " R8 irq_out"}, 32'(irq_out), 32'(pend != 0));
        check({tag, " R5 mask_out"}, mask_out, m_mask);
        check({tag, " R7 sel_valid"}, 32'(sel_valid), 32'(e_valid));
        check({tag, " R3 sel_index"}, 32'(sel_index), 32'(e_idx));
        check({tag, " R6 sel_is_external"}, 32'(sel_is_external), 32'(e_ext));
        check({tag, " R6 sel_ext_line"}, 32'(sel_ext_line), 32'(e_line));
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset mask", mask_out, 32'h0);
        check("R9 reset irq", 32'(irq_out), 32'h0);
        check("R9 reset valid", 32'(sel_valid), 32'h0);

        // R1 R2: all requesting but mask zero, nothing pending
        step("R1 masked", 32'hFFFF_FFFF, 1'b0, 2'b11, 0, 0, 1'b1);
        // R5 load whole mask
        step("R5 load", 32'hFFFF_FFFF, 1'b1, 2'b00, 32'hFFFF_FFFF, 0, 1'b0);
        // R3 R4 fair rotation 0,1,2
        step("R4 rot0", 32'hFFFF_FFFF, 1'b0, 2'b11, 0, 0, 1'b1);
        step("R4 rot1", 32'hFFFF_FFFF, 1'b0, 2'b11, 0, 0, 1'b1);
        step("R4 rot2", 32'hFFFF_FFFF, 1'b0, 2'b11, 0, 0, 1'b1);
        // R3 wrap: only bit 1 pending, pointer at 3
        step("R3 wrap", 32'h0000_0002, 1'b0, 2'b11, 0, 0, 1'b1);
        // R6 external window pick
        step("R6 ext", 32'h2000_0000, 1'b0, 2'b11, 0, 0, 1'b1);
        // R10 clear bit 29 in same cycle as request: old mask used
        step("R10 same", 32'h2000_0000, 1'b1, 2'b10, 0, 5'd29, 1'b1);
        // R2 nothing pending now; pointer must stay
        step("R2 idle", 32'h2000_0000, 1'b0, 2'b11, 0, 0, 1'b1);
        step("R2 after", 32'h8000_0001, 1'b0, 2'b11, 0, 0, 1'b1);
        // R5 single set, hold op
        step("R5 set", 32'h0, 1'b1, 2'b01, 0, 5'd29, 1'b0);
        step("R5 hold", 32'h0, 1'b1, 2'b11, 32'h1234_5678, 5'd3, 1'b0);

        for (int n = 0; n < 4000; n++) begin
            logic [31:0] st = $urandom() & $urandom();
            logic        wr = ($urandom() % 4) == 0;
            logic [1:0]  op = 2'($urandom());
            step("R1 R10 random", st, wr, op, $urandom(), 5'($urandom()),
                 ($urandom() % 2) == 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule